// File: doc/BRIEF.md
# Dual-Loop Lock Detector with Power Control

This block produces a single lock indication for a frequency synthesizer that runs a main loop and an auxiliary loop. Each loop delivers two single-cycle pulses per comparison: one from the reference path and one from the divided path. Both are synchronous to the reference clock. A comparison passes when the two pulses are no more than `LOCK_TOL` reference-clock cycles apart. A loop's lock flag follows the result of its most recent completed comparison.

Power for each loop comes from a shared hardware pin and a per-loop software bit, combined by exclusive-OR. With the pin low, a software bit of 1 powers the loop up. With the pin high, the polarity of the software bits is inverted. The combined lock output considers only the loops that are powered. When a loop wakes up, the block issues a one-cycle synchronizing pulse to that loop's main and reference dividers. The loop's lock flag then stays cleared until a fresh comparison passes.

Top module: `dual_lock_power`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all outputs are 0.
- R2: Each loop enable (`mainEn`, `auxEn`) becomes the value of `pwrPin` XOR that loop's software bit one clock after the inputs are applied. With `pwrPin` at 0, a software bit of 1 enables the loop.
- R3: A loop's divider sync output is high for exactly one cycle, the first cycle in which its enable reads 1. A falling enable or a steady enable produces no pulse.
- R4: Reference and divided pulses in the same cycle form a passing comparison, a distance of 0. The loop's lock flag reads 1 from the following cycle.
- R5: A pulse followed by the other kind of pulse one cycle later, in either order, is a passing comparison. The distance is 1, which is within the default `LOCK_TOL` of 1.
- R6: If the other kind of pulse has not arrived within `LOCK_TOL` cycles of the first, the comparison fails and the loop's lock flag reads 0. A second pulse of the same kind does not complete the comparison.
- R7: In the cycle where the sync pulse is high, pulses on that loop are ignored. After a wake-up, the loop's flag stays 0 until a later comparison passes.
- R8: With both loops enabled, `lockOut` is 1 only when both flags are 1. With one loop enabled, `lockOut` follows that loop's flag alone.
- R9: With both loops disabled, `lockOut` is 0.
- R10: With `pwrPin` at 1, a software bit of 0 enables the loop and a software bit of 1 disables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrPin | input | 1 | Hardware power polarity pin |
| mainSwPd | input | 1 | Software power bit, main loop |
| auxSwPd | input | 1 | Software power bit, auxiliary loop |
| mainRef | input | 1 | Main loop reference pulse |
| mainDiv | input | 1 | Main loop divided pulse |
| auxRef | input | 1 | Auxiliary loop reference pulse |
| auxDiv | input | 1 | Auxiliary loop divided pulse |
| lockOut | output | 1 | Combined lock indication |
| mainEn | output | 1 | Main loop enable |
| auxEn | output | 1 | Auxiliary loop enable |
| mainDivSync | output | 1 | Main loop divider sync pulse |
| auxDivSync | output | 1 | Auxiliary loop divider sync pulse |

## Verification
The embedded assertions check the following on every cycle:
- the sync pulse never lasts longer than one cycle;
- the sync pulse only appears on a fresh enable;
- the window counter stays inside its tolerance;
- a lock flag never rises without a sampled pulse behind it;
- a flag is clear after a wake-up or a disabled cycle.

Only the bench scenarios can show how the combined output reacts to each mix of powered loops. The same applies to the pin inverting the software polarity, to the distinction between a same-kind repeat and a matching edge, and to pulses that arrive during the sync cycle leaving no trace.

// File: rtl/dual_lock_pkg.sv
package dual_lock_pkg;
  localparam int NLOOP = 2;
  localparam int MAIN_IDX = 0;
  localparam int AUX_IDX = 1;

  typedef struct packed {
    logic [NLOOP-1:0] run;
    logic [NLOOP-1:0] restart;
  } ctrlStrobe_t;
endpackage

// File: rtl/dual_lock_ctrl.sv
module dual_lock_ctrl
  import dual_lock_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             pwrPin,
  input  logic [NLOOP-1:0] swPd,
  output ctrlStrobe_t      strobe,
  output logic [NLOOP-1:0] en,
  output logic [NLOOP-1:0] divSync
);
  logic [NLOOP-1:0] enReg;
  logic [NLOOP-1:0] enPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      enReg  <= '0;
      enPrev <= '0;
    end else begin
      enReg  <= {NLOOP{pwrPin}} ^ swPd;
      enPrev <= enReg;
    end
  end

  assign en             = enReg;
  assign divSync        = enReg & ~enPrev;
  assign strobe.run     = enReg;
  assign strobe.restart = divSync;

  for (genvar i = 0; i < NLOOP; i++) begin : g_chk
    AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (rst)
      divSync[i] |=> !divSync[i]); // R3
    AST_SYNC_ON_WAKE: assert property (@(posedge clk) disable iff (rst)
      divSync[i] |-> (en[i] && !$past(en[i]))); // R3
  end
endmodule

// File: rtl/dual_lock_window.sv
module dual_lock_window #(
  parameter int LOCK_TOL = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  input  logic refPulse,
  input  logic divPulse,
  output logic lockFlag
);
  localparam int CW = (LOCK_TOL < 1) ? 1 : $clog2(LOCK_TOL + 1);
  localparam logic [CW-1:0] TOL_V = CW'(LOCK_TOL);

  logic          waiting;
  logic          seenRef;
  logic [CW-1:0] cnt;
  logic          otherEdge;

  assign otherEdge = seenRef ? divPulse : refPulse;

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      waiting  <= 1'b0;
      seenRef  <= 1'b0;
      cnt      <= '0;
      lockFlag <= 1'b0;
    end else if (!waiting) begin
      if (refPulse && divPulse) begin
        lockFlag <= 1'b1;
      end else if (refPulse || divPulse) begin
        waiting <= 1'b1;
        seenRef <= refPulse;
        cnt     <= CW'(1);
      end
    end else if (otherEdge) begin
      lockFlag <= 1'b1;
      waiting  <= 1'b0;
    end else if (cnt >= TOL_V) begin
      lockFlag <= 1'b0;
      waiting  <= 1'b0;
    end else begin
      cnt <= CW'(cnt + 1'b1);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    waiting |-> (cnt >= CW'(1) && cnt <= TOL_V)); // R6
  AST_WAKE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    restart |=> !lockFlag); // R7
  AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !run |=> !lockFlag); // R9
  AST_LOCK_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(lockFlag) |-> $past(run && !restart && (refPulse || divPulse))); // R4
endmodule

// File: rtl/dual_lock_path.sv
module dual_lock_path
  import dual_lock_pkg::*;
#(
  parameter int LOCK_TOL = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobe_t      strobe,
  input  logic [NLOOP-1:0] refPulse,
  input  logic [NLOOP-1:0] divPulse,
  output logic             lockOut
);
  logic [NLOOP-1:0] flags;

  for (genvar i = 0; i < NLOOP; i++) begin : g_loop
    dual_lock_window #(.LOCK_TOL(LOCK_TOL)) u_win (
      .clk      (clk),
      .rst      (rst),
      .run      (strobe.run[i]),
      .restart  (strobe.restart[i]),
      .refPulse (refPulse[i]),
      .divPulse (divPulse[i]),
      .lockFlag (flags[i])
    );
  end

  assign lockOut = (|strobe.run) && (&(~strobe.run | flags));
endmodule

// File: rtl/dual_lock_power.sv
module dual_lock_power
  import dual_lock_pkg::*;
#(
  parameter int LOCK_TOL = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic pwrPin,
  input  logic mainSwPd,
  input  logic auxSwPd,
  input  logic mainRef,
  input  logic mainDiv,
  input  logic auxRef,
  input  logic auxDiv,
  output logic lockOut,
  output logic mainEn,
  output logic auxEn,
  output logic mainDivSync,
  output logic auxDivSync
);
  ctrlStrobe_t      strobe;
  logic [NLOOP-1:0] en;
  logic [NLOOP-1:0] divSync;
  logic [NLOOP-1:0] swPd;
  logic [NLOOP-1:0] refPulse;
  logic [NLOOP-1:0] divPulse;

  assign swPd[MAIN_IDX]     = mainSwPd;
  assign swPd[AUX_IDX]      = auxSwPd;
  assign refPulse[MAIN_IDX] = mainRef;
  assign refPulse[AUX_IDX]  = auxRef;
  assign divPulse[MAIN_IDX] = mainDiv;
  assign divPulse[AUX_IDX]  = auxDiv;

  dual_lock_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .pwrPin  (pwrPin),
    .swPd    (swPd),
    .strobe  (strobe),
    .en      (en),
    .divSync (divSync)
  );

  dual_lock_path #(.LOCK_TOL(LOCK_TOL)) u_path (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .refPulse (refPulse),
    .divPulse (divPulse),
    .lockOut  (lockOut)
  );

  assign mainEn      = en[MAIN_IDX];
  assign auxEn       = en[AUX_IDX];
  assign mainDivSync = divSync[MAIN_IDX];
  assign auxDivSync  = divSync[AUX_IDX];
endmodule

// File: tb/dual_lock_power_test.sv
`timescale 1ns/1ps
module dual_lock_power_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwrPin = 1'b0, mainSwPd = 1'b0, auxSwPd = 1'b0;
  logic mainRef = 1'b0, mainDiv = 1'b0, auxRef = 1'b0, auxDiv = 1'b0;
  logic lockOut, mainEn, auxEn, mainDivSync, auxDivSync;

  int cycle = 0;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    int         cyc;
    logic [4:0] vec;
    string      tag;
  } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;

  dual_lock_power uut (
    .clk(clk), .rst(rst), .pwrPin(pwrPin), .mainSwPd(mainSwPd), .auxSwPd(auxSwPd),
    .mainRef(mainRef), .mainDiv(mainDiv), .auxRef(auxRef), .auxDiv(auxDiv),
    .lockOut(lockOut), .mainEn(mainEn), .auxEn(auxEn),
    .mainDivSync(mainDivSync), .auxDivSync(auxDivSync)
  );

  always @(posedge clk) cycle <= cycle + 1;

  // monitor: vec = {lockOut, mainEn, auxEn, mainDivSync, auxDivSync}
  always @(posedge clk) begin
    #2;
    while (sbq.size() > 0 && sbq[0].cyc == cycle) begin
      item_t it;
      logic [4:0] act;
      it = sbq.pop_front();
      act = {lockOut, mainEn, auxEn, mainDivSync, auxDivSync};
      total++;
      if (act !== it.vec) begin
        bad++;
        $display("FAIL %s: actual=%b expected=%b (cycle %0d)", it.tag, act, it.vec, cycle);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic [4:0] v, input string tag);
    item_t it;
    it.cyc = cycle;
    it.vec = v;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    tick(); tick();
    chk(5'b00000, "R1 in reset");
    rst = 1'b0;
    tick();
    chk(5'b00000, "R1 after reset");

    // main wake-up, pulses during sync cycle must be ignored
    mainSwPd = 1'b1;
    tick(); chk(5'b01010, "R2 R3 main wake");
    mainRef = 1'b1; mainDiv = 1'b1;
    tick(); mainRef = 1'b0; mainDiv = 1'b0;
    chk(5'b01000, "R3 R7 sync cycle");
    tick(); chk(5'b01000, "R7 no lock from sync-cycle pulses");

    // same-cycle edges
    mainRef = 1'b1; mainDiv = 1'b1;
    tick(); mainRef = 1'b0; mainDiv = 1'b0;
    chk(5'b11000, "R4 R8 same cycle");

    // ref alone, then nothing -> fail
    mainRef = 1'b1;
    tick(); mainRef = 1'b0;
    chk(5'b11000, "R6 window open");
    tick(); chk(5'b01000, "R6 missing div");

    // div then ref one cycle later
    mainDiv = 1'b1;
    tick(); mainDiv = 1'b0;
    chk(5'b01000, "R5 waiting");
    mainRef = 1'b1;
    tick(); mainRef = 1'b0;
    chk(5'b11000, "R5 div first");

    // ref repeated is not a match
    mainRef = 1'b1;
    tick(); chk(5'b11000, "R6 first ref");
    tick(); mainRef = 1'b0;
    chk(5'b01000, "R6 same-kind repeat");

    // ref then div one cycle later
    mainRef = 1'b1;
    tick(); mainRef = 1'b0;
    mainDiv = 1'b1;
    tick(); mainDiv = 1'b0;
    chk(5'b11000, "R5 ref first");

    // aux wakes: combined lock needs both
    auxSwPd = 1'b1;
    tick(); chk(5'b01101, "R3 R8 aux wake");
    tick(); chk(5'b01100, "R8 aux unlocked");
    auxRef = 1'b1; auxDiv = 1'b1;
    tick(); auxRef = 1'b0; auxDiv = 1'b0;
    chk(5'b11100, "R8 both locked");

    // main fails while aux stays locked
    mainRef = 1'b1;
    tick(); mainRef = 1'b0;
    chk(5'b11100, "R8 window open");
    tick(); chk(5'b01100, "R8 main lost");

    // main off: aux alone
    mainSwPd = 1'b0;
    tick(); chk(5'b10100, "R8 R3 main off");
    tick(); chk(5'b10100, "R3 no pulse on fall");

    // both off
    auxSwPd = 1'b0;
    tick(); chk(5'b00000, "R9 both off");

    // pin inverts polarity
    pwrPin = 1'b1;
    tick(); chk(5'b01111, "R10 R3 pin wake");
    tick(); chk(5'b01100, "R7 flags clear after wake");
    mainRef = 1'b1; mainDiv = 1'b1; auxRef = 1'b1; auxDiv = 1'b1;
    tick(); mainRef = 1'b0; mainDiv = 1'b0; auxRef = 1'b0; auxDiv = 1'b0;
    chk(5'b11100, "R10 R8 both locked");
    mainSwPd = 1'b1;
    tick(); chk(5'b10100, "R10 bit 1 powers down");

    // aux alone fails
    auxRef = 1'b1;
    tick(); auxRef = 1'b0;
    chk(5'b10100, "R6 aux window open");
    tick(); chk(5'b00100, "R6 aux missing div");

    auxSwPd = 1'b1;
    tick(); chk(5'b00000, "R9 R10 both off");

    tick(); tick();
    if (sbq.size() != 0) begin
      total++;
      bad++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", sbq.size());
    end
    finish_run();
  end
endmodule